// File: doc/BRIEF.md
# Self-Stepping Operand Address Generator

This block generates operand addresses for a datapath that reads and writes one of several small on-chip data memories. Software loads a pointer and a signed step, called the modifier, through a configuration write port. It also selects one of four stepping modes and an element size. From then on, each pulse on the access strobe does two things. In that cycle it presents the current pointer as the memory address and raises the enable line of the target memory. It also moves the pointer for the next access. The datapath therefore never spends an instruction on address arithmetic or on an explicit load or store.

Linear stepping walks an array with any signed stride. Circular stepping keeps the pointer inside a window, which suits delay lines and filter histories. Bit-reversed stepping visits the elements of a power-of-two block in the order an FFT reorder pass needs. Fixed mode keeps the pointer still, so a scalar can be reused. The block holds no data and does not consume any.

Top module: `step_addr_gen`

## Requirements
- R1: After synchronous reset, the pointer, modifier, base and length are all zero. The mode is linear, the element size is 1 byte, the memory index is 0 and the bit count field is 0. With no access, `addr_o` is 0 and every select and strobe output is low.
- R2: While `acc_i` is high, `addr_o` shows the current pointer in that same cycle. `mem_sel_o` has exactly bit k set, where k is the configured memory index. `mem_wr_o` equals `acc_wr_i` and `mem_rd_o` equals its inverse. With `acc_i` low, all three outputs are low.
- R3: In linear mode (mode code 0), the pointer after an access is the pointer plus the modifier times the element size in bytes. The modifier is read as a two's-complement MOD_W-bit value, and the sum wraps modulo 2^ADDR_W. Size code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes.
- R4: In circular mode (code 1), the stepped value is first computed as in R3. If it is at or above base+length, the length is subtracted. If it is below base, the length is added. A pointer inside [base, base+length) therefore stays inside it, provided the step magnitude is less than the length.
- R5: In bit-reversed mode (code 2), the element index is (pointer − base) divided by the element size, truncated to n bits. The block increments that index with the carry running from bit n−1 down to bit 0, and the new pointer is base + index × size. The modifier is ignored in this mode.
- R6: In fixed mode (code 3), an access leaves the pointer unchanged.
- R7: A cycle with neither an access nor a configuration write leaves the pointer unchanged.
- R8: A configuration write in the same cycle as an access takes priority. The access uses the old pointer, and its step is discarded. Only a write to the pointer field then changes the pointer, and it takes the written value.
- R9: The configuration address selects a field: 0 is the pointer, 1 the modifier (low MOD_W bits), 2 the base, 3 the length and 4 the control word. Addresses 5 to 7 change nothing. In the control word, bits [1:0] hold the mode, bits [3:2] the size code, bits [5:4] the memory index and bits [11:8] the bit count n.
- R10: A bit count of 0 acts as 1, and a bit count above BR_MAX (12 by default) acts as BR_MAX.
- R11: A memory index at or above NMEM selects no memory. The pointer still steps.
- R12: Size code 3 steps like size code 2, that is, 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration field select |
| cfg_data_i | input | ADDR_W | Configuration write data |
| acc_i | input | 1 | Operand access strobe |
| acc_wr_i | input | 1 | Access direction: 1 write, 0 read |
| addr_o | output | ADDR_W | Memory address (current pointer) |
| mem_sel_o | output | NMEM | One-hot memory enable |
| mem_rd_o | output | 1 | Read strobe to selected memory |
| mem_wr_o | output | 1 | Write strobe to selected memory |

## Verification
The address, select and strobe outputs of an access are due in the same cycle as the strobe, since `addr_o` is the pointer register itself. The stepped pointer appears only in the following cycle, at the next access. The driver applies inputs just after a rising edge and pushes the expected item. The monitor pops it at the falling edge of that same cycle, after the pointer register has settled from the previous edge. Idle checks sample `addr_o` at a falling edge with the strobe low, which proves the pointer held over cycles with no access.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef enum logic [1:0] {
    AM_LINEAR = 2'd0,
    AM_CIRC   = 2'd1,
    AM_BITREV = 2'd2,
    AM_FIXED  = 2'd3
  } amode_e;

  localparam logic [2:0] FLD_PTR  = 3'd0;
  localparam logic [2:0] FLD_MOD  = 3'd1;
  localparam logic [2:0] FLD_BASE = 3'd2;
  localparam logic [2:0] FLD_LEN  = 3'd3;
  localparam logic [2:0] FLD_CTRL = 3'd4;

  // control word layout
  localparam int CTL_MODE_LSB = 0;
  localparam int CTL_SIZE_LSB = 2;
  localparam int CTL_MEM_LSB  = 4;
  localparam int CTL_NB_LSB   = 8;
  localparam int MEM_IDX_W    = 2;

  // element size code -> byte shift (code 3 behaves as 4 bytes)
  function automatic logic [1:0] size_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/sag_cfg_bank.sv
module sag_cfg_bank
  import sag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MOD_W  = 12,
  parameter int BRW    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [2:0]           fld_i,
  input  logic [ADDR_W-1:0]    data_i,
  output logic [MOD_W-1:0]     mod_o,
  output logic [ADDR_W-1:0]    base_o,
  output logic [ADDR_W-1:0]    len_o,
  output amode_e               mode_o,
  output logic [1:0]           size_o,
  output logic [MEM_IDX_W-1:0] mem_o,
  output logic [BRW-1:0]       nbits_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_o   <= '0;
      base_o  <= '0;
      len_o   <= '0;
      mode_o  <= AM_LINEAR;
      size_o  <= 2'd0;
      mem_o   <= '0;
      nbits_o <= '0;
    end else if (we_i) begin
      case (fld_i)
        FLD_MOD:  mod_o  <= data_i[MOD_W-1:0];
        FLD_BASE: base_o <= data_i;
        FLD_LEN:  len_o  <= data_i;
        FLD_CTRL: begin
          mode_o  <= amode_e'(data_i[CTL_MODE_LSB +: 2]);
          size_o  <= data_i[CTL_SIZE_LSB +: 2];
          mem_o   <= data_i[CTL_MEM_LSB +: MEM_IDX_W];
          nbits_o <= data_i[CTL_NB_LSB +: BRW];
        end
        default: ;
      endcase
    end
  end

  // R9: control word fields land where the map puts them
  p_ctrl_fields_r9: assert property (@(posedge clk) disable iff (rst)
    (we_i && fld_i == FLD_CTRL) |=>
      (mode_o == $past(data_i[1:0]) && size_o == $past(data_i[3:2]) &&
       nbits_o == $past(data_i[CTL_NB_LSB +: BRW])));

  // R9: unused field addresses leave the configuration untouched
  p_unused_fld_r9: assert property (@(posedge clk) disable iff (rst)
    (we_i && fld_i > FLD_CTRL) |=>
      ($stable(mod_o) && $stable(base_o) && $stable(len_o) && $stable(mode_o)));

endmodule

// File: rtl/sag_step_unit.sv
module sag_step_unit
  import sag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MOD_W  = 12,
  parameter int BR_MAX = 12,
  parameter int BRW    = 4
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [MOD_W-1:0]  mod_i,
  input  amode_e            mode_i,
  input  logic [1:0]        size_i,
  input  logic [BRW-1:0]    nbits_i,
  output logic [ADDR_W-1:0] next_o
);

  localparam int EW = ADDR_W + 2;

  logic [1:0]           sh;
  logic signed [EW-1:0] step_s, ptr_s, base_s, len_s, end_s, sum_s, circ_s;
  logic [ADDR_W-1:0]    lin_a, circ_a, brev_a;

  assign sh     = size_shift(size_i);
  assign step_s = EW'($signed(mod_i)) <<< sh;
  assign ptr_s  = $signed({2'b00, ptr_i});
  assign base_s = $signed({2'b00, base_i});
  assign len_s  = $signed({2'b00, len_i});
  assign sum_s  = ptr_s + step_s;
  assign end_s  = base_s + len_s;

  // linear: plain wrap-around add
  assign lin_a = ptr_i + ADDR_W'(step_s);

  // circular: one correction in either direction
  always_comb begin
    if (sum_s >= end_s)       circ_s = sum_s - len_s;
    else if (sum_s < base_s)  circ_s = sum_s + len_s;
    else                      circ_s = sum_s;
  end
  assign circ_a = ADDR_W'(circ_s);

  // bit-reversed: reverse, add one, reverse back, within n bits
  logic [BRW-1:0]    nb_eff, rsh;
  logic [ADDR_W-1:0] off;
  logic [BR_MAX-1:0] mask, idx, idx_rev, fwd, fwd_inc, inc_rev, back;

  always_comb begin
    if (nbits_i == '0)                 nb_eff = BRW'(1);
    else if (nbits_i > BRW'(BR_MAX))   nb_eff = BRW'(BR_MAX);
    else                               nb_eff = nbits_i;
  end

  assign rsh  = BRW'(BR_MAX) - nb_eff;
  assign mask = {BR_MAX{1'b1}} >> rsh;
  assign off  = ptr_i - base_i;
  assign idx  = BR_MAX'(off >> sh) & mask;

  for (genvar g = 0; g < BR_MAX; g++) begin : g_rev
    assign idx_rev[g] = idx[BR_MAX-1-g];
    assign inc_rev[g] = fwd_inc[BR_MAX-1-g];
  end

  assign fwd     = idx_rev >> rsh;
  assign fwd_inc = (fwd + 1'b1) & mask;
  assign back    = inc_rev >> rsh;
  assign brev_a  = base_i + (ADDR_W'(back) << sh);

  always_comb begin
    case (mode_i)
      AM_LINEAR: next_o = lin_a;
      AM_CIRC:   next_o = circ_a;
      AM_BITREV: next_o = brev_a;
      default:   next_o = ptr_i;
    endcase
  end

endmodule

// File: rtl/sag_mem_decode.sv
module sag_mem_decode
  import sag_pkg::*;
#(
  parameter int NMEM = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_i,
  input  logic                 wr_i,
  input  logic [MEM_IDX_W-1:0] idx_i,
  output logic [NMEM-1:0]      sel_o,
  output logic                 rd_o,
  output logic                 wr_o
);

  for (genvar g = 0; g < NMEM; g++) begin : g_sel
    assign sel_o[g] = acc_i && (idx_i == MEM_IDX_W'(g));
  end

  assign rd_o = acc_i && !wr_i;
  assign wr_o = acc_i && wr_i;

  // R2: never more than one memory enabled
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));

  // R11: out-of-range index enables nothing
  p_sel_range_r11: assert property (@(posedge clk) disable iff (rst)
    (int'(idx_i) >= NMEM) |-> (sel_o == '0));

endmodule

// File: rtl/step_addr_gen.sv
module step_addr_gen
  import sag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MOD_W  = 12,
  parameter int NMEM   = 3,
  parameter int BR_MAX = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              acc_i,
  input  logic              acc_wr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NMEM-1:0]   mem_sel_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o
);

  localparam int BRW = $clog2(BR_MAX + 1);

  logic [ADDR_W-1:0]    ptr_q, ptr_nxt, base_q, len_q;
  logic [MOD_W-1:0]     mod_q;
  amode_e               mode_q;
  logic [1:0]           size_q;
  logic [MEM_IDX_W-1:0] mem_q;
  logic [BRW-1:0]       nbits_q;

  sag_cfg_bank #(.ADDR_W(ADDR_W), .MOD_W(MOD_W), .BRW(BRW)) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .fld_i(cfg_addr_i), .data_i(cfg_data_i),
    .mod_o(mod_q), .base_o(base_q), .len_o(len_q), .mode_o(mode_q),
    .size_o(size_q), .mem_o(mem_q), .nbits_o(nbits_q)
  );

  sag_step_unit #(.ADDR_W(ADDR_W), .MOD_W(MOD_W), .BR_MAX(BR_MAX), .BRW(BRW)) u_step (
    .ptr_i(ptr_q), .base_i(base_q), .len_i(len_q), .mod_i(mod_q),
    .mode_i(mode_q), .size_i(size_q), .nbits_i(nbits_q), .next_o(ptr_nxt)
  );

  sag_mem_decode #(.NMEM(NMEM)) u_dec (
    .clk(clk), .rst(rst), .acc_i(acc_i), .wr_i(acc_wr_i), .idx_i(mem_q),
    .sel_o(mem_sel_o), .rd_o(mem_rd_o), .wr_o(mem_wr_o)
  );

  // pointer register: configuration write beats the access step
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == FLD_PTR) ptr_q <= cfg_data_i;
    end else if (acc_i) begin
      ptr_q <= ptr_nxt;
    end
  end

  assign addr_o = ptr_q;

  // checker-side step magnitude for the circular window property
  logic signed [ADDR_W+1:0] chk_step;
  logic        [ADDR_W+1:0] chk_abs;
  assign chk_step = (ADDR_W+2)'($signed(mod_q)) <<< size_shift(size_q);
  assign chk_abs  = chk_step[ADDR_W+1] ? (ADDR_W+2)'(-chk_step) : (ADDR_W+2)'(chk_step);

  // R7: idle cycles keep the pointer
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!acc_i && !cfg_we_i) |=> $stable(addr_o));

  // R6: fixed mode never moves the pointer
  p_fixed_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_i && !cfg_we_i && mode_q == AM_FIXED) |=> $stable(addr_o));

  // R8: a pointer write wins over a simultaneous access
  p_cfg_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && cfg_addr_i == FLD_PTR) |=> (addr_o == $past(cfg_data_i)));

  // R8: a non-pointer write discards the access step
  p_step_dropped_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && cfg_addr_i != FLD_PTR) |=> $stable(addr_o));

  // R4: circular stepping stays inside the window
  p_circ_window_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_i && !cfg_we_i && mode_q == AM_CIRC && chk_abs < {2'b00, len_q} &&
     {1'b0, ptr_q} >= {1'b0, base_q} && {1'b0, ptr_q} < {1'b0, base_q} + {1'b0, len_q})
    |=> ({1'b0, addr_o} >= {1'b0, $past(base_q)} &&
         {1'b0, addr_o} <  {1'b0, $past(base_q)} + {1'b0, $past(len_q)}));

  // R5: bit-reversed stepping stays within the largest block above base
  p_brev_block_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_i && !cfg_we_i && mode_q == AM_BITREV) |=>
      ((ADDR_W+2)'(addr_o - $past(base_q)) < (ADDR_W+2)'(1) << (BR_MAX + 2)));

endmodule

// File: tb/step_addr_gen_test.sv
module step_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [15:0] cfg_data = 16'd0;
  logic        acc = 1'b0;
  logic        acc_wr = 1'b0;
  logic [15:0] addr;
  logic [2:0]  sel;
  logic        rd, wr;

  always #4 clk = ~clk;  // 125 MHz

  step_addr_gen uut (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .acc_i(acc), .acc_wr_i(acc_wr), .addr_o(addr), .mem_sel_o(sel),
    .mem_rd_o(rd), .mem_wr_o(wr)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  typedef struct packed {
    logic [15:0] a;
    logic [2:0]  s;
    logic        r;
    logic        w;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // bench model of the configuration
  logic [15:0] m_ptr = 0, m_base = 0, m_len = 0;
  logic [11:0] m_mod = 0;
  logic [1:0]  m_mode = 0, m_size = 0, m_mem = 0;
  logic [3:0]  m_nb = 0;

  function automatic logic [15:0] ref_next();
    int bytes = (m_size == 2'd0) ? 1 : (m_size == 2'd1) ? 2 : 4;
    int shv   = (m_size == 2'd0) ? 0 : (m_size == 2'd1) ? 1 : 2;
    int stp   = int'($signed(m_mod)) * bytes;
    int t;
    int nb;
    logic [15:0] idx;
    case (m_mode)
      2'd0: return 16'(int'(m_ptr) + stp);
      2'd1: begin
        t = int'(m_ptr) + stp;
        if (t >= int'(m_base) + int'(m_len)) t = t - int'(m_len);
        else if (t < int'(m_base)) t = t + int'(m_len);
        return 16'(t);
      end
      2'd2: begin
        nb = (m_nb == 0) ? 1 : (m_nb > 12) ? 12 : int'(m_nb);
        idx = 16'(m_ptr - m_base) >> shv;
        idx = idx & 16'((1 << nb) - 1);
        for (int b = nb - 1; b >= 0; b--) begin
          if (idx[b]) idx[b] = 1'b0;
          else begin
            idx[b] = 1'b1;
            break;
          end
        end
        return m_base + (idx << shv);
      end
      default: return m_ptr;
    endcase
  endfunction

  task automatic apply_cfg(input logic [2:0] a, input logic [15:0] d);
    case (a)
      3'd0: m_ptr = d;
      3'd1: m_mod = d[11:0];
      3'd2: m_base = d;
      3'd3: m_len = d;
      3'd4: begin
        m_mode = d[1:0]; m_size = d[3:2]; m_mem = d[5:4]; m_nb = d[11:8];
      end
      default: ;
    endcase
  endtask

  // driver: one cycle of stimulus, expected item pushed for each access
  task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d,
                      input bit ac, input bit w);
    exp_t e;
    @(posedge clk); #1;
    cfg_we = we; cfg_addr = a; cfg_data = d; acc = ac; acc_wr = w;
    if (ac) begin
      e.a = m_ptr;
      e.s = (m_mem < 2'd3) ? (3'b001 << m_mem) : 3'b000;
      e.r = !w;
      e.w = w;
      exp_q.push_back(e);
      tag_q.push_back(cur_req);
    end
    if (we) apply_cfg(a, d);
    else if (ac) m_ptr = ref_next();
  endtask

  task automatic cfg(input logic [2:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic accs(input int n, input bit w);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'd0, 1'b1, w);
  endtask

  task automatic idle_check(input string req, input logic [15:0] exp_a);
    step(1'b0, 3'd0, 16'd0, 1'b0, 1'b0);
    @(negedge clk);
    checks++;
    if (addr !== exp_a || sel !== 3'b000 || rd !== 1'b0 || wr !== 1'b0) begin
      failures++;
      $display("FAIL %s idle: addr=%h sel=%b rd=%b wr=%b expected addr=%h sel=000 rd=0 wr=0",
               req, addr, sel, rd, wr, exp_a);
    end
  endtask

  function automatic logic [15:0] ctrl(input int mode, input int size, input int mem, input int nb);
    return 16'((nb << 8) | (mem << 4) | (size << 2) | mode);
  endfunction

  // monitor: compares each access in its own cycle
  always @(negedge clk) begin
    if (!rst && acc && !done) begin
      exp_t  e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected access: addr=%h expected no access", cur_req, addr);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (addr !== e.a || sel !== e.s || rd !== e.r || wr !== e.w) begin
          failures++;
          $display("FAIL %s access: addr=%h sel=%b rd=%b wr=%b expected addr=%h sel=%b rd=%b wr=%b",
                   t, addr, sel, rd, wr, e.a, e.s, e.r, e.w);
        end
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    idle_check("R1", 16'h0000);
    accs(2, 1'b0);  // mod 0, linear: stays at 0 on memory 0

    // R2: direction strobes and memory selects
    cur_req = "R2";
    cfg(3'd4, ctrl(0, 0, 1, 0));
    cfg(3'd1, 16'd1);
    accs(1, 1'b1);
    accs(1, 1'b0);
    cfg(3'd4, ctrl(0, 0, 2, 0));
    accs(2, 1'b1);

    // R3: linear, 2-byte elements, then negative 4-byte stride across zero
    cur_req = "R3";
    cfg(3'd4, ctrl(0, 1, 0, 0));
    cfg(3'd0, 16'h0100);
    cfg(3'd1, 16'd3);
    accs(4, 1'b0);
    cfg(3'd4, ctrl(0, 2, 0, 0));
    cfg(3'd0, 16'h0004);
    cfg(3'd1, 16'h0FFF);  // -1
    accs(4, 1'b0);

    // R12: size code 3 is 4 bytes
    cur_req = "R12";
    cfg(3'd4, ctrl(0, 3, 0, 0));
    cfg(3'd0, 16'h0040);
    cfg(3'd1, 16'd2);
    accs(3, 1'b0);

    // R4: circular window, forward and backward
    cur_req = "R4";
    cfg(3'd2, 16'h0200);
    cfg(3'd3, 16'h0020);
    cfg(3'd0, 16'h0218);
    cfg(3'd1, 16'd3);
    cfg(3'd4, ctrl(1, 2, 0, 0));
    accs(6, 1'b0);
    cfg(3'd0, 16'h0202);
    cfg(3'd1, 16'h0FFB);  // -5
    cfg(3'd4, ctrl(1, 0, 0, 0));
    accs(6, 1'b1);

    // R5: bit-reversed, 8 elements of 2 bytes, modifier ignored
    cur_req = "R5";
    cfg(3'd2, 16'h0400);
    cfg(3'd0, 16'h0400);
    cfg(3'd1, 16'd7);
    cfg(3'd4, ctrl(2, 1, 0, 3));
    accs(9, 1'b0);

    // R10: bit count clamping
    cur_req = "R10";
    cfg(3'd2, 16'h0500);
    cfg(3'd0, 16'h0500);
    cfg(3'd4, ctrl(2, 0, 0, 0));
    accs(3, 1'b0);
    cfg(3'd4, ctrl(2, 0, 0, 15));
    accs(4, 1'b0);

    // R6: fixed mode
    cur_req = "R6";
    cfg(3'd0, 16'h0777);
    cfg(3'd4, ctrl(3, 0, 1, 0));
    accs(3, 1'b1);

    // R7: idle cycles in linear mode keep the pointer
    cur_req = "R7";
    cfg(3'd4, ctrl(0, 0, 0, 0));
    cfg(3'd1, 16'd5);
    cfg(3'd0, 16'h0123);
    idle_check("R7", 16'h0123);
    idle_check("R7", 16'h0123);
    accs(1, 1'b0);
    idle_check("R7", 16'h0128);

    // R8: pointer write during an access
    cur_req = "R8";
    step(1'b1, 3'd0, 16'h0900, 1'b1, 1'b0);
    accs(2, 1'b0);
    // non-pointer write during an access drops the step
    step(1'b1, 3'd1, 16'd16, 1'b1, 1'b1);
    accs(2, 1'b0);

    // R9: unused field addresses change nothing
    cur_req = "R9";
    cfg(3'd5, 16'hFFFF);
    cfg(3'd6, 16'hFFFF);
    cfg(3'd7, 16'hFFFF);
    accs(2, 1'b0);

    // R11: out-of-range memory index selects nothing, pointer still steps
    cur_req = "R11";
    cfg(3'd4, ctrl(0, 0, 3, 0));
    cfg(3'd1, 16'd1);
    accs(2, 1'b1);
    idle_check("R11", m_ptr);

    step(1'b0, 3'd0, 16'd0, 1'b0, 1'b0);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 pending accesses: got %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL %s watchdog: run did not end, expected completion", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule